// File: doc/BRIEF.md
# Linear Photodiode Array Readout Sequencer

This block generates the start-pulse line (`si`) and the pixel clock (`sclk`) for a linear photodiode array whose pixels come out serially on one analog line. An external sampling converter runs alongside it. The block does not use a free-running pixel clock. Each rising edge of `sclk` is launched by the converter's sample-ready event, so the array moves its next pixel onto the analog line as soon as the converter begins its next conversion. Each accepted sample is then written to a pixel store through a plain address/data write strobe. Because the clock edges track the converter, an uneven sampling rate never misaligns pixels and samples.

A readout begins with a start-pulse/clock handshake that moves the pixel charges into the array's shift register. The block then enables the converter and runs one clock-high, store, clock-low step per sample until the configured number of pixels is stored. After that it stops the converter and gives one more clock pulse to put the array output back into high impedance. A clear command runs the same start pulse, followed by `pix_count + 1` clock pulses, and stores nothing. After reset the clear runs twice without being asked, which flushes whatever charge the array holds at power-up.

Samples arrive on a valid/ready stream. `smp_ready` is high only while the sequencer waits for the next pixel, with the clock low and the low phase already complete. A converter that offers a sample while `smp_ready` is low must keep `smp_valid` and `smp_data` steady until the handshake cycle. The write port has no back-pressure: the store must accept every `wr_en` cycle. `PHASE_CYC` must be at least 2. With the default value of 5 and a 100 MHz clock, each clock phase lasts at least 50 ns.

Top module: `lpa_readout_seq`

## Requirements
- R1: After reset `si`, `sclk`, `wr_en`, `smp_ready` and `done` are 0. Two clear sequences then run by themselves, using `pix_count`. Together they give two `si` pulses and 2·(N+2) `sclk` rising edges, no writes, and exactly one `done` pulse, at the end.
- R2: A readout starts with `si` high for PHASE_CYC cycles, then `si` and `sclk` high together for PHASE_CYC cycles, then both low. The first `sclk` rising edge of a readout occurs while `si` is 1. `conv_start` pulses exactly once per readout.
- R3: `sclk` rises in the clock cycle immediately after a handshake cycle (`smp_valid` and `smp_ready` both 1).
- R4: `wr_en` pulses for one cycle, one cycle after that rising edge, while `sclk` is still high. `sclk` falls PHASE_CYC cycles after it rose. No other `wr_en` pulse occurs.
- R5: Every high phase and every low phase of `sclk` (apart from the idle level after reset) lasts at least PHASE_CYC cycles.
- R6: Writes use addresses 0, 1, …, N−1 in order, where N is `pix_count` captured at the start strobe. `wr_data` is the sample accepted at that pixel's handshake.
- R7: After the N-th write, `conv_stop` pulses once. One more `sclk` pulse follows, then `done` pulses. A readout therefore produces N+2 `sclk` rising edges.
- R8: A clear command gives one `si` pulse and N+2 `sclk` rising edges. It produces no `wr_en` and no `conv_start`, and ends with one `done` pulse.
- R9: A start or clear strobe that arrives while a sequence is running, including the power-up clears, is ignored. If both strobes arrive together while idle, start wins.
- R10: `smp_ready` is 0 whenever `sclk` or `si` is high. A sample held valid while `smp_ready` is 0 is accepted later with its data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start-readout strobe, honoured only when idle |
| clear_cmd | input | 1 | Flush strobe, honoured only when idle |
| pix_count | input | PIX_W | Number of pixels N (1 or more for a readout), captured when a sequence starts |
| smp_valid | input | 1 | Converter sample valid |
| smp_ready | output | 1 | Sequencer waiting for the next pixel sample |
| smp_data | input | DATA_W | Converter sample value |
| si | output | 1 | Array start pulse |
| sclk | output | 1 | Array pixel clock |
| conv_start | output | 1 | One-cycle pulse to enable the converter |
| conv_stop | output | 1 | One-cycle pulse to halt the converter |
| wr_en | output | 1 | Pixel store write strobe |
| wr_addr | output | PIX_W | Pixel store address |
| wr_data | output | DATA_W | Pixel store data |
| done | output | 1 | One-cycle pulse at the end of a sequence |

## Verification
`sclk` goes high one cycle after the handshake edge, and `wr_en` follows one cycle after that. The converter model records each handshake as it drives it. The monitor, sampling on falling edges, uses that record at the next falling edge to require the rising `sclk`, and at the one after to require the write. Counts of `si` pulses, `sclk` edges, writes and converter pulses are compared with N+2 and N once `done` has been seen. Phase widths are checked on every change of `sclk` against the cycles counted since the previous change. The sweep covers every N from 1 to 6 under three sample-spacing patterns, one of which offers samples before `smp_ready`. It also injects start and clear strobes in the middle of sequences.

// File: rtl/lpa_pkg.sv
package lpa_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SI_SET,
    ST_SI_CLK,
    ST_SI_END,
    ST_FL_HI,
    ST_FL_LO,
    ST_WAIT,
    ST_PX_HI,
    ST_PX_LO,
    ST_TL_HI,
    ST_TL_LO
  } seq_state_e;
endpackage

// File: rtl/lpa_phase_timer.sv
module lpa_phase_timer #(
  parameter int PHASE_CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reload,
  output logic expired,
  output logic at_first
);
  localparam int CW = $clog2(PHASE_CYC + 1);
  localparam logic [CW-1:0] LOADV = CW'(PHASE_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (reload)      cnt <= LOADV;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired  = (cnt == '0);
  assign at_first = (cnt == LOADV);

  assert_timer_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LOADV);
endmodule

// File: rtl/lpa_pix_counter.sv
module lpa_pix_counter #(
  parameter int PIX_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic [PIX_W-1:0] limit,
  output logic [PIX_W-1:0] count,
  output logic             at_limit
);
  always_ff @(posedge clk) begin
    if (!rst_n)     count <= '0;
    else if (clr)   count <= '0;
    else if (inc)   count <= count + 1'b1;
  end

  assign at_limit = (count == limit);

  assert_no_overrun_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr) |-> !at_limit);
endmodule

// File: rtl/lpa_readout_seq.sv
module lpa_readout_seq
  import lpa_pkg::*;
#(
  parameter int PIX_W     = 11,
  parameter int DATA_W    = 8,
  parameter int PHASE_CYC = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              clear_cmd,
  input  logic [PIX_W-1:0]  pix_count,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [DATA_W-1:0] smp_data,
  output logic              si,
  output logic              sclk,
  output logic              conv_start,
  output logic              conv_stop,
  output logic              wr_en,
  output logic [PIX_W-1:0]  wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              done
);
  localparam int RW = $clog2(PHASE_CYC + 1);

  seq_state_e st, nxt;
  logic       tmo, t_first, reload;
  logic       clr_mode;
  logic [1:0] boot_left;
  logic [PIX_W-1:0] n_q, pcount;
  logic       at_lim, cnt_inc, cnt_clr, go_read, go_clr;
  logic       si_q, sclk_q, wr_en_q, cstart_q, cstop_q, done_q;
  logic [PIX_W-1:0]  addr_q;
  logic [DATA_W-1:0] data_q;
  logic       sclk_nxt, si_nxt;
  logic [RW-1:0] run_len;

  lpa_phase_timer #(.PHASE_CYC(PHASE_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .reload(reload),
    .expired(tmo), .at_first(t_first));

  lpa_pix_counter #(.PIX_W(PIX_W)) u_count (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc),
    .limit(n_q), .count(pcount), .at_limit(at_lim));

  always_comb begin
    nxt     = st;
    go_read = 1'b0;
    go_clr  = 1'b0;
    cnt_inc = 1'b0;
    cnt_clr = 1'b0;
    case (st)
      ST_IDLE: begin
        if (boot_left != 2'd0) go_clr  = 1'b1;
        else if (start)        go_read = 1'b1;
        else if (clear_cmd)    go_clr  = 1'b1;
        if (go_read || go_clr) begin
          nxt     = ST_SI_SET;
          cnt_clr = 1'b1;
        end
      end
      ST_SI_SET: if (tmo) nxt = ST_SI_CLK;
      ST_SI_CLK: if (tmo) nxt = ST_SI_END;
      ST_SI_END: if (tmo) nxt = clr_mode ? ST_FL_HI : ST_WAIT;
      ST_FL_HI:  if (tmo) nxt = ST_FL_LO;
      ST_FL_LO: if (tmo) begin
        if (at_lim) nxt = ST_IDLE;
        else begin
          nxt     = ST_FL_HI;
          cnt_inc = 1'b1;
        end
      end
      ST_WAIT:  if (smp_valid) nxt = ST_PX_HI;
      ST_PX_HI: begin
        cnt_inc = t_first;
        if (tmo) nxt = ST_PX_LO;
      end
      ST_PX_LO: if (tmo) nxt = at_lim ? ST_TL_HI : ST_WAIT;
      ST_TL_HI: if (tmo) nxt = ST_TL_LO;
      ST_TL_LO: if (tmo) nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  assign reload   = (nxt != st);
  assign sclk_nxt = (nxt == ST_SI_CLK) || (nxt == ST_FL_HI) ||
                    (nxt == ST_PX_HI)  || (nxt == ST_TL_HI);
  assign si_nxt   = (nxt == ST_SI_SET) || (nxt == ST_SI_CLK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      clr_mode  <= 1'b0;
      boot_left <= 2'd2;
      n_q       <= '0;
      si_q      <= 1'b0;
      sclk_q    <= 1'b0;
      wr_en_q   <= 1'b0;
      addr_q    <= '0;
      data_q    <= '0;
      cstart_q  <= 1'b0;
      cstop_q   <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      st       <= nxt;
      si_q     <= si_nxt;
      sclk_q   <= sclk_nxt;
      if (go_read || go_clr) begin
        clr_mode <= go_clr;
        n_q      <= pix_count;
      end
      if (go_clr && boot_left != 2'd0) boot_left <= boot_left - 2'd1;
      if (st == ST_WAIT && smp_valid) data_q <= smp_data;
      wr_en_q  <= (st == ST_PX_HI) && t_first;
      if ((st == ST_PX_HI) && t_first) addr_q <= pcount;
      cstart_q <= (st == ST_SI_END) && (nxt == ST_WAIT);
      cstop_q  <= (st == ST_PX_LO) && (nxt == ST_TL_HI);
      done_q   <= (st != ST_IDLE) && (nxt == ST_IDLE) && (boot_left == 2'd0);
    end
  end

  assign smp_ready  = (st == ST_WAIT);
  assign si         = si_q;
  assign sclk       = sclk_q;
  assign wr_en      = wr_en_q;
  assign wr_addr    = addr_q;
  assign wr_data    = data_q;
  assign conv_start = cstart_q;
  assign conv_stop  = cstop_q;
  assign done       = done_q;

  // cycles the clock line has held its present level (saturating)
  always_ff @(posedge clk) begin
    if (!rst_n)                 run_len <= RW'(PHASE_CYC);
    else if (sclk_nxt != sclk_q) run_len <= RW'(1);
    else if (run_len < RW'(PHASE_CYC)) run_len <= run_len + 1'b1;
  end

  assert_rise_after_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ready) |=> (sclk && !$past(sclk)));

  assert_store_in_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (sclk && $past(sclk)));

  assert_min_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk != $past(sclk)) |-> ($past(run_len) >= RW'(PHASE_CYC)));

  assert_addr_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_addr < n_q));

  assert_ready_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    smp_ready |-> (!sclk && !si));

  assert_stop_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    conv_stop |-> (at_lim && !wr_en));
endmodule

// File: tb/lpa_readout_seq_test.sv
module lpa_readout_seq_test;
  localparam int PIX_W = 11;
  localparam int DATA_W = 8;
  localparam int PHASE = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, clear_cmd = 1'b0;
  logic [PIX_W-1:0] pix_count = 11'd3;
  logic smp_valid = 1'b0;
  logic [DATA_W-1:0] smp_data = '0;
  logic smp_ready, si, sclk, conv_start, conv_stop, wr_en, done;
  logic [PIX_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;

  always #5 clk = ~clk;

  lpa_readout_seq #(.PIX_W(PIX_W), .DATA_W(DATA_W), .PHASE_CYC(PHASE)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .clear_cmd(clear_cmd),
    .pix_count(pix_count), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .si(si), .sclk(sclk), .conv_start(conv_start),
    .conv_stop(conv_stop), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .done(done));

  int tests = 0, fails = 0;
  bit finished = 0;
  int cur_n = 3, cur_pat = 0;
  int rises = 0, si_rises = 0, wr_cnt = 0, n_cstart = 0, n_cstop = 0, n_done = 0;
  bit hs_pending = 0, wr_exp = 0, seen_edge = 0;
  logic prev_sclk = 0, prev_si = 0;
  int run = 0;

  function automatic int pix_val(int i);
    return (i * 53 + cur_n * 17 + cur_pat * 91 + 7) & 255;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic zero_counts();
    rises = 0; si_rises = 0; wr_cnt = 0; n_cstart = 0; n_cstop = 0; n_done = 0;
  endtask

  // port monitor, samples on falling edges
  always @(negedge clk) begin
    if (!rst_n) begin
      chk(!si && !sclk && !wr_en && !smp_ready && !done, "R1 reset outputs",
          {si, sclk, wr_en, smp_ready, done}, 0);
    end else begin
      if (wr_exp) chk(wr_en, "R4 write after rise", wr_en, 1);
      else if (wr_en) chk(0, "R4 stray write", 1, 0);
      wr_exp = 0;
      if (wr_en) begin
        chk(wr_addr == PIX_W'(wr_cnt), "R6 address", wr_addr, wr_cnt);
        chk(wr_data == DATA_W'(pix_val(wr_cnt)), "R6 data", wr_data, pix_val(wr_cnt));
        wr_cnt++;
      end
      if (hs_pending) begin
        chk(sclk && !prev_sclk, "R3 rise after handshake", sclk, 1);
        hs_pending = 0;
        wr_exp = 1;
      end
      if (sclk != prev_sclk) begin
        if (seen_edge) chk(run >= PHASE, "R5 phase width", run, PHASE);
        seen_edge = 1;
        if (sclk) begin
          if (rises == 0) chk(si, "R2 first clock under si", si, 1);
          rises++;
        end
        run = 1;
      end else run++;
      if (si && !prev_si) si_rises++;
      if (smp_ready && (sclk || si)) chk(0, "R10 ready while busy", 1, 0);
      if (conv_start) n_cstart++;
      if (conv_stop) begin
        n_cstop++;
        chk(wr_cnt == cur_n, "R7 stop after last write", wr_cnt, cur_n);
      end
      if (done) n_done++;
      prev_sclk = sclk;
      prev_si = si;
    end
  end

  task automatic wait_done();
    while (n_done == 0) begin
      @(negedge clk); #1;
    end
    repeat (3) @(negedge clk);
    #1;
  endtask

  task automatic run_read(input int n, input int pat, input bit poke);
    zero_counts();
    cur_n = n; cur_pat = pat;
    pix_count = PIX_W'(n);
    @(negedge clk); #1 start = 1;
    @(negedge clk); #1 start = 0;
    for (int i = 0; i < n; i++) begin
      int gap;
      gap = (pat == 0) ? 0 : (pat == 1) ? (i % 3) * 4 : 9 - (i % 4);
      repeat (gap) begin @(negedge clk); #1; end
      smp_valid = 1; smp_data = DATA_W'(pix_val(i));
      while (!smp_ready) begin @(negedge clk); #1; end
      hs_pending = 1;
      @(negedge clk); #1 smp_valid = 0; smp_data = '0;
      if (poke && i == 0) begin
        start = 1; clear_cmd = 1;
        @(negedge clk); #1 start = 0; clear_cmd = 0;
      end
    end
    wait_done();
    chk(wr_cnt == n, "R6 write count", wr_cnt, n);
    chk(rises == n + 2, "R7 clock pulses", rises, n + 2);
    chk(si_rises == 1, "R2 si pulses", si_rises, 1);
    chk(n_cstart == 1, poke ? "R9 start ignored" : "R2 converter start", n_cstart, 1);
    chk(n_cstop == 1, "R7 converter stop", n_cstop, 1);
    chk(n_done == 1, "R7 done", n_done, 1);
  endtask

  task automatic run_clear(input int n);
    zero_counts();
    cur_n = n;
    pix_count = PIX_W'(n);
    @(negedge clk); #1 clear_cmd = 1;
    @(negedge clk); #1 clear_cmd = 0;
    repeat (12) @(negedge clk);
    #1 start = 1;
    @(negedge clk); #1 start = 0;
    wait_done();
    chk(rises == n + 2, "R8 clear pulses", rises, n + 2);
    chk(si_rises == 1, "R8 clear si", si_rises, 1);
    chk(wr_cnt == 0, "R8 no writes", wr_cnt, 0);
    chk(n_cstart == 0, "R8 R9 no converter start", n_cstart, 0);
    chk(n_done == 1, "R8 done", n_done, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    #1 rst_n = 1;
    repeat (20) @(negedge clk);
    #1 start = 1;                 // arrives during power-up flush
    @(negedge clk); #1 start = 0;
    wait_done();
    chk(rises == 10, "R1 boot clock pulses", rises, 10);
    chk(si_rises == 2, "R1 boot si pulses", si_rises, 2);
    chk(wr_cnt == 0, "R1 boot writes", wr_cnt, 0);
    chk(n_cstart == 0, "R1 R9 boot start ignored", n_cstart, 0);
    chk(n_done == 1, "R1 boot done", n_done, 1);
    for (int pat = 0; pat < 3; pat++)
      for (int n = 1; n <= 6; n++)
        run_read(n, pat, pat == 1);
    run_clear(1);
    run_clear(4);
    run_clear(7);
    run_read(9, 2, 1'b0);
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule